// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash and decides, from plain read cycles alone, whether an embedded program or erase has finished. After a start pulse it reads the status location through a request/acknowledge read port. It compares bit 6 across consecutive reads, which the device flips on every read while its internal algorithm runs. It also watches bit 5, which the device raises when its internal time limit is exceeded.

The poller produces one verdict per run: success, failure or timeout. Failure means the toggle bit kept moving after the limit flag appeared. In that case the poller first writes the reset command byte so that the device returns to array reads. Timeout means a parameterised number of toggling pairs with bit 5 clear was used up. The device and its bus timing are outside the block.

Top module: `toggle_poller`

## Requirements
- R1: After reset, rd_req, wr_req and done are 0 and result is 2'b00.
- R2: A start pulse makes rd_req high on the next cycle, with rd_addr equal to the op_addr sampled with start. A start that arrives while a run is in progress abandons it: no done is produced for the abandoned run, and no stored bit 6 value or pair count carries over.
- R3: Reads come in pairs. Bit 6 of the first read of a pair is stored. If bit 6 of the second read equals it, the run ends with success (result 2'b01) and no further read is made.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, a new pair is read.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 1, exactly two more reads are made. Equal bit 6 values in this re-test pair give success.
- R6: If bit 6 still differs in the re-test pair, wr_req rises with wr_data 8'hF0 and wr_addr equal to op_addr, and is held until wr_ack. The run then ends with failure (result 2'b10).
- R7: When MAX_PAIRS pairs in a row have shown a toggling bit 6 with bit 5 clear, the run ends with timeout (result 2'b11) and no further read is made.
- R8: rd_req and wr_req are never high together. result is never 2'b00 while done is high. result keeps its value until the next start, which clears it to 2'b00.
- R9: done is a one-cycle strobe in the cycle after the acknowledge that ends the run. Neither request is high while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a poll run |
| op_addr | input | ADDR_W | Status location to poll, sampled with start |
| rd_req | output | 1 | Read request, held until rd_ack |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | One-cycle read completion, rd_data valid |
| rd_data | input | 8 | Byte returned by the read |
| wr_req | output | 1 | Write request for the reset command |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write byte (reset command) |
| wr_ack | input | 1 | One-cycle write completion |
| done | output | 1 | One-cycle end-of-run strobe |
| result | output | 2 | 01 success, 10 failure, 11 timeout |

## Verification
On every cycle, the assertions check the following: the two request ports are mutually exclusive; a start leads straight to a read request; done lasts one cycle and carries a non-zero code; a failure verdict is always preceded by a completed reset-command write; and the pair counter stays below its limit. Which verdict a given device behaviour must yield, and after how many reads, can only be shown by the bench's scenarios. The bench sweeps the cycle at which the device stops toggling against the cycle at which it raises bit 5, under several read latencies. It then checks the verdict and the exact read and write counts against an arithmetic model. A restart in the middle of a run shows that no pair count survives the restart.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned TGL_POS = 6;
  localparam int unsigned LIM_POS = 5;
  localparam logic [7:0] RESET_BYTE = 8'hF0;

  localparam logic [1:0] RES_NONE    = 2'b00;
  localparam logic [1:0] RES_OK      = 2'b01;
  localparam logic [1:0] RES_FAIL    = 2'b10;
  localparam logic [1:0] RES_TIMEOUT = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAIR_A,
    ST_PAIR_B,
    ST_RECHK_A,
    ST_RECHK_B,
    ST_RST_WR
  } tp_state_e;

  // bit 6 moved between two samples
  function automatic logic toggled(input logic prev_bit, input logic [7:0] cur);
    return prev_bit ^ cur[TGL_POS];
  endfunction

  // device reports it exceeded its internal limit
  function automatic logic limit_hit(input logic [7:0] cur);
    return cur[LIM_POS];
  endfunction
endpackage

// File: rtl/tp_sampler.sv
module tp_sampler
  import tp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       capture,
  input  logic [7:0] cur_data,
  output logic       held_bit,
  output logic       moved,
  output logic       lim
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) held_bit <= 1'b0;
    else if (capture)    held_bit <= cur_data[TGL_POS];
  end

  assign moved = toggled(held_bit, cur_data);
  assign lim   = limit_hit(cur_data);
endmodule

// File: rtl/tp_budget.sv
module tp_budget #(
  parameter int unsigned MAX_PAIRS = 4,
  localparam int unsigned CNT_W = $clog2(MAX_PAIRS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (bump)       count <= count + CNT_W'(1);
  end

  assign last = (count == CNT_W'(MAX_PAIRS - 1));
endmodule

// File: rtl/tp_seq.sv
module tp_seq
  import tp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_ack,
  input  logic       wr_ack,
  input  logic       moved,
  input  logic       lim,
  input  logic       last,
  output logic       rd_req,
  output logic       wr_req,
  output logic       capture,
  output logic       clear,
  output logic       bump,
  output logic       fin_ok,
  output logic       fin_fail,
  output logic       fin_tmo,
  output logic       done,
  output logic [1:0] result
);
  tp_state_e st_q, st_d;
  logic       done_q;
  logic [1:0] res_q;

  always_comb begin
    st_d     = st_q;
    rd_req   = 1'b0;
    wr_req   = 1'b0;
    capture  = 1'b0;
    clear    = 1'b0;
    bump     = 1'b0;
    fin_ok   = 1'b0;
    fin_fail = 1'b0;
    fin_tmo  = 1'b0;
    unique case (st_q)
      ST_IDLE: ;
      ST_PAIR_A, ST_RECHK_A: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          capture = 1'b1;
          st_d = (st_q == ST_PAIR_A) ? ST_PAIR_B : ST_RECHK_B;
        end
      end
      ST_PAIR_B: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          if (!moved)    fin_ok = 1'b1;
          else if (lim)  st_d = ST_RECHK_A;
          else if (last) fin_tmo = 1'b1;
          else begin
            bump = 1'b1;
            st_d = ST_PAIR_A;
          end
        end
      end
      ST_RECHK_B: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          if (!moved) fin_ok = 1'b1;
          else        st_d = ST_RST_WR;
        end
      end
      ST_RST_WR: begin
        wr_req = 1'b1;
        if (wr_ack) fin_fail = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin_ok || fin_fail || fin_tmo) st_d = ST_IDLE;
    if (start) begin
      st_d     = ST_PAIR_A;
      clear    = 1'b1;
      capture  = 1'b0;
      bump     = 1'b0;
      fin_ok   = 1'b0;
      fin_fail = 1'b0;
      fin_tmo  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      res_q  <= RES_NONE;
    end else begin
      st_q   <= st_d;
      done_q <= fin_ok | fin_fail | fin_tmo;
      if (start)         res_q <= RES_NONE;
      else if (fin_ok)   res_q <= RES_OK;
      else if (fin_fail) res_q <= RES_FAIL;
      else if (fin_tmo)  res_q <= RES_TIMEOUT;
    end
  end

  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
  import tp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MAX_PAIRS = 4096,
  localparam int unsigned CNT_W = $clog2(MAX_PAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic [1:0]        result
);
  logic [ADDR_W-1:0] addr_q;
  logic              capture, clear, bump, last;
  logic              moved, lim, held_bit;
  logic              fin_ok, fin_fail, fin_tmo;
  logic [CNT_W-1:0]  pair_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (start) addr_q <= op_addr;
  end

  tp_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture),
    .cur_data(rd_data), .held_bit(held_bit), .moved(moved), .lim(lim)
  );

  tp_budget #(.MAX_PAIRS(MAX_PAIRS)) u_bud (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bump(bump),
    .count(pair_cnt), .last(last)
  );

  tp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_ack(rd_ack), .wr_ack(wr_ack),
    .moved(moved), .lim(lim), .last(last),
    .rd_req(rd_req), .wr_req(wr_req), .capture(capture), .clear(clear),
    .bump(bump), .fin_ok(fin_ok), .fin_fail(fin_fail), .fin_tmo(fin_tmo),
    .done(done), .result(result)
  );

  assign rd_addr = addr_q;
  assign wr_addr = addr_q;
  assign wr_data = RESET_BYTE;
endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int unsigned MAX_PAIRS = 4,
  localparam int unsigned CNT_W = $clog2(MAX_PAIRS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rd_req,
  input logic             wr_req,
  input logic             wr_ack,
  input logic [7:0]       wr_data,
  input logic             done,
  input logic [1:0]       result,
  input logic             fin_ok,
  input logic [CNT_W-1:0] pair_cnt
);
  a_r2_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rd_req && !wr_req));

  a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  a_r8_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'b00));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req && !wr_req));

  a_r3_ok_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_ok && !start) |=> (done && result == 2'b01));

  a_r6_write_before_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'b10) |-> $past(wr_req && wr_ack));

  a_r6_write_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_data == 8'hF0));

  a_r7_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pair_cnt < CNT_W'(MAX_PAIRS));
endmodule

bind toggle_poller tp_chk #(.MAX_PAIRS(MAX_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .wr_req(wr_req),
  .wr_ack(wr_ack), .wr_data(wr_data), .done(done), .result(result),
  .fin_ok(fin_ok), .pair_cnt(pair_cnt)
);

// File: tb/sim_toggle_poller.sv
module sim_toggle_poller;
  localparam int AW = 16;
  localparam int MP = 4;
  localparam logic [7:0] FINAL_BYTE = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic rd_req, wr_req, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  logic [1:0] result;
  logic rd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic wr_ack = 1'b0;

  int n_tests = 0, n_fail = 0;
  int dev_b = 0, dev_t = 0, lat = 0;
  int rk = 0, rcnt = 0, wcnt = 0, nwrites = 0;
  logic [AW-1:0] seen_rd_addr, seen_wr_addr;
  logic [7:0] seen_wr_data;
  logic addr_bad = 1'b0;

  always #4 clk = ~clk;

  toggle_poller #(.ADDR_W(AW), .MAX_PAIRS(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_addr(op_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .result(result)
  );

  // device stand-in: toggles bit 6 for reads below dev_b, bit 5 set from dev_t on
  function automatic logic [7:0] dev_byte(input int k, input int b, input int t);
    logic [7:0] v;
    if (k < b) begin
      v = 8'h00;
      v[6] = k[0];
      v[5] = (k >= t);
      return v;
    end
    return FINAL_BYTE;
  endfunction

  // arithmetic model of the expected verdict and read count
  function automatic void model(input int b, input int t, input int m,
                                output int code, output int nrd);
    int k = 0, pairs = 0;
    logic [7:0] x, y;
    code = 0;
    while (code == 0) begin
      x = dev_byte(k, b, t); y = dev_byte(k + 1, b, t); k += 2;
      if (x[6] == y[6]) code = 1;
      else if (y[5]) begin
        x = dev_byte(k, b, t); y = dev_byte(k + 1, b, t); k += 2;
        code = (x[6] == y[6]) ? 1 : 2;
      end else begin
        pairs++;
        if (pairs == m) code = 3;
      end
    end
    nrd = k;
  endfunction

  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack = 1'b0; rcnt = 0;
    end else if (rd_req) begin
      if (rcnt >= lat) begin
        rd_ack = 1'b1; rd_data = dev_byte(rk, dev_b, dev_t); rk++;
        seen_rd_addr = rd_addr;
        if (rd_addr != op_addr) addr_bad = 1'b1;
        rcnt = 0;
      end else rcnt++;
    end
    if (wr_ack) begin
      wr_ack = 1'b0; wcnt = 0;
    end else if (wr_req) begin
      if (wcnt >= 2) begin
        wr_ack = 1'b1; nwrites++;
        seen_wr_data = wr_data; seen_wr_addr = wr_addr; wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    @(negedge clk);
    op_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int code);
    int guard = 0;
    code = 0;
    while (!done && guard < 2000) begin
      @(negedge clk); guard++;
    end
    if (done) code = int'(result);
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic prep(input int b, input int t, input int l);
    dev_b = b; dev_t = t; lat = l;
    rk = 0; nwrites = 0; addr_bad = 1'b0;
  endtask

  initial begin
    int ecode, enrd, got;
    int vw = 0;
    repeat (3) @(negedge clk);
    chk(!rd_req && !wr_req && !done && result == 2'b00, "R1 reset state",
        int'(result), 0);
    rst_n = 1'b1;

    for (int b = 0; b < 10; b++) begin
      for (int t = 0; t < 11; t++) begin
        prep(b, t, (b + t) % 3);
        model(b, t, MP, ecode, enrd);
        pulse_start(AW'(16'h1000 + b * 16 + t));
        wait_done(got);
        case (ecode)
          1: chk(got == 1, "R3/R5 success verdict", got, ecode);
          2: chk(got == 2, "R6 failure verdict", got, ecode);
          default: chk(got == 3, "R7 timeout verdict", got, ecode);
        endcase
        chk(rk == enrd, "R4/R5/R7 read count", rk, enrd);
        chk(!addr_bad, "R2 read address", int'(seen_rd_addr), int'(op_addr));
        chk(nwrites == ((ecode == 2) ? 1 : 0), "R6 reset write count", nwrites,
            (ecode == 2) ? 1 : 0);
        if (ecode == 2)
          chk(seen_wr_data == 8'hF0 && seen_wr_addr == op_addr, "R6 reset write byte",
              int'(seen_wr_data), 8'hF0);
        chk(result == 2'(got), "R8 result held", int'(result), got);
      end
    end

    // R2: restart mid-run, pair count must not carry over
    prep(10, 99, 2);
    pulse_start(16'h2222);
    while (rk < 6) @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(result == 2'b00 && !done, "R8 start clears result", int'(result), 0);
    wait_done(got);
    chk(got == 1, "R2 restart forgets pair count", got, 1);
    chk(rk == 12, "R2 restart read count", rk, 12);

    // R7 exact boundary with a slow responder
    prep(40, 99, 3);
    pulse_start(16'h3333);
    wait_done(got);
    chk(got == 3 && rk == 2 * MP, "R7 stop at budget", rk, 2 * MP);
    repeat (5) @(negedge clk);
    chk(!rd_req && rk == 2 * MP, "R7 no read after timeout", rk, 2 * MP);

    vw = n_fail;
    $display("  [TB] %0d tests run, %0d failed", n_tests, vw);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule